// File: doc/BRIEF.md
# Fetch-to-Decode Instruction Queue with Replay

This block sits between an instruction fetch stage and a decode stage. In any cycle, fetch offers a bundle of up to `N` instruction slots. A per-slot valid mask marks which slots hold real instructions. A per-slot prediction mask, together with one target address, marks the slot that ends in a predicted branch. The queue compacts the valid slots into an instruction FIFO that holds `4*N` entries. When a valid slot carries a prediction, the target address goes into a separate two-entry address FIFO. Decode takes one instruction per cycle whenever it signals ready.

Sometimes a bundle cannot be stored in full. This happens when the instruction FIFO lacks room for every valid slot, or when the bundle carries a prediction and the address FIFO already holds two targets. In that case the queue raises a combinational replay request, stores nothing from the bundle, and fetch issues the same bundle again later. A flush empties both FIFOs in a single cycle.

Top module: `fetch_replay_queue`

## Requirements
- R1: After reset both FIFOs are empty, `deq_valid_o` is 0, `replay_o` is 0 and `ready_o` is 1.
- R2: An accepted bundle writes its valid slots only, with slot 0 (bits `IW-1:0` of `fetch_instr_i`) first. Decode receives them in that slot order, after everything stored before them.
- R3: The instruction FIFO holds up to `4*N` entries. A bundle with `fetch_valid_i` high is replayed when the number of free entries, counted before this cycle's pop, is smaller than the number of set bits in `fetch_vmask_i`. A bundle that fits exactly is accepted.
- R4: The address FIFO holds 2 targets. A bundle counts as predicted when `fetch_pred_i & fetch_vmask_i` is nonzero, and at most one such bit may be set. A predicted bundle is replayed while the address FIFO is full, even when the instruction FIFO has room.
- R5: In a cycle with `replay_o` high, no instruction and no target from the bundle is stored, so a later re-issue is not duplicated.
- R6: `deq_valid_o` is high exactly when the instruction FIFO is not empty. The head is removed only at a clock edge where `deq_valid_o` and `deq_ready_i` are both high.
- R7: When the head instruction carries a prediction, `deq_pred_o` is 1 and `deq_target_o` shows its target. That target leaves the address FIFO in the same cycle as the instruction.
- R8: `flush_i` empties both FIFOs at the next edge. While it is high, `replay_o` is 0 and neither the bundle nor the pop takes effect.
- R9: `ready_o` is 1 exactly when at least `N` instruction entries are free and the address FIFO is not full.
- R10: With `fetch_valid_i` low nothing is written. Prediction bits on slots whose valid bit is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty both FIFOs |
| fetch_valid_i | input | 1 | A fetch bundle is offered |
| fetch_instr_i | input | N*IW | Instruction slots, slot k at bits k*IW +: IW |
| fetch_vmask_i | input | N | Per-slot valid bits |
| fetch_pred_i | input | N | Per-slot predicted-branch bits |
| fetch_target_i | input | AW | Predicted target of the bundle |
| replay_o | output | 1 | Bundle not accepted, re-issue it |
| ready_o | output | 1 | Room for a full bundle |
| deq_valid_o | output | 1 | Head instruction available |
| deq_ready_i | input | 1 | Decode takes the head |
| deq_instr_o | output | IW | Head instruction |
| deq_pred_o | output | 1 | Head carries a prediction |
| deq_target_o | output | AW | Target belonging to the head |

## Verification
The bench fills the instruction FIFO to its exact capacity. A design with an off-by-one full test would either replay a bundle that fits or overwrite entries that decode has not yet read. It also piles up predicted one-instruction bundles while decode stalls, which exposes a replay that ignores the address FIFO; such a design would lose or mismatch targets. A reference queue checks instruction order against replays, flushes, invalid slots with stray prediction bits, and pops in the same cycle as pushes. This catches duplicated re-issued bundles and targets that drift away from their instructions.

// File: rtl/fetch_replay_queue.sv
module fetch_replay_queue #(
  parameter int N  = 2,
  parameter int IW = 32,
  parameter int AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            fetch_valid_i,
  input  logic [N*IW-1:0] fetch_instr_i,
  input  logic [N-1:0]    fetch_vmask_i,
  input  logic [N-1:0]    fetch_pred_i,
  input  logic [AW-1:0]   fetch_target_i,
  output logic            replay_o,
  output logic            ready_o,
  output logic            deq_valid_o,
  input  logic            deq_ready_i,
  output logic [IW-1:0]   deq_instr_o,
  output logic            deq_pred_o,
  output logic [AW-1:0]   deq_target_o
);
  localparam int DEPTH = 4 * N;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int XW    = CW + 1;
  localparam int PW    = $clog2(DEPTH);

  logic [IW-1:0]    imem [DEPTH];
  logic [DEPTH-1:0] pbit;
  logic [AW-1:0]    amem [2];
  logic [PW-1:0]    rd, wr;
  logic [CW-1:0]    cnt, nval, free;
  logic [CW-1:0]    off [N];
  logic             ard, awr;
  logic [1:0]       acnt;
  logic             has_pred, push, pop, apush, apop;

  function automatic logic [PW-1:0] wrap(input logic [XW-1:0] a);
    return (a >= XW'(DEPTH)) ? PW'(a - XW'(DEPTH)) : PW'(a);
  endfunction

  always_comb begin
    nval = '0;
    for (int i = 0; i < N; i++) begin
      off[i] = nval;
      nval   = nval + CW'(fetch_vmask_i[i]);
    end
  end

  assign has_pred    = |(fetch_pred_i & fetch_vmask_i);
  assign free        = CW'(DEPTH) - cnt;
  assign replay_o    = fetch_valid_i && !flush_i &&
                       ((free < nval) || (has_pred && acnt == 2'd2));
  assign push        = fetch_valid_i && !flush_i && !replay_o;
  assign apush       = push && has_pred;
  assign ready_o     = (free >= CW'(N)) && (acnt != 2'd2);
  assign deq_valid_o = (cnt != '0);
  assign deq_instr_o = imem[rd];
  assign deq_pred_o  = deq_valid_o && pbit[rd];
  assign deq_target_o = amem[ard];
  assign pop         = deq_valid_o && deq_ready_i && !flush_i;
  assign apop        = pop && pbit[rd];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd   <= '0;
      wr   <= '0;
      cnt  <= '0;
      ard  <= 1'b0;
      awr  <= 1'b0;
      acnt <= '0;
    end else if (flush_i) begin
      rd   <= '0;
      wr   <= '0;
      cnt  <= '0;
      ard  <= 1'b0;
      awr  <= 1'b0;
      acnt <= '0;
    end else begin
      if (push) wr <= wrap(XW'(wr) + XW'(nval));
      if (pop)  rd <= wrap(XW'(rd) + XW'(1));
      cnt  <= cnt + (push ? nval : '0) - CW'(pop);
      if (apush) awr <= ~awr;
      if (apop)  ard <= ~ard;
      acnt <= acnt + 2'(apush) - 2'(apop);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (push && fetch_vmask_i[i]) begin
        imem[wrap(XW'(wr) + XW'(off[i]))] <= fetch_instr_i[i*IW +: IW];
        pbit[wrap(XW'(wr) + XW'(off[i]))] <= fetch_pred_i[i];
      end
    end
    if (apush) amem[awr] <= fetch_target_i;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));  // R3
  AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acnt <= 2'd2);  // R4
  AST_REPLAY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |=> (cnt + CW'($past(pop))) == $past(cnt));  // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt == '0) && (acnt == 2'd0));  // R8
  AST_PRED_HAS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_pred_o |-> acnt != 2'd0);  // R7
  AST_HOLD_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deq_ready_i && !flush_i && !fetch_valid_i) |=> cnt == $past(cnt));  // R6
endmodule

// File: tb/tb_fetch_replay_queue.sv
module tb_fetch_replay_queue;
  localparam int N = 2, IW = 32, AW = 32, DEPTH = 4 * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush, fv, dr;
  logic [N*IW-1:0] instr;
  logic [N-1:0] vmask, pmask;
  logic [AW-1:0] tgt;
  logic replay, ready, dv, dpred;
  logic [IW-1:0] dinstr;
  logic [AW-1:0] dtgt;

  int checks = 0, fails = 0;
  logic [IW-1:0] qi[$];
  logic          qp[$];
  logic [AW-1:0] qa[$];
  bit was_flush = 0;

  always #5 clk = ~clk;

  fetch_replay_queue #(.N(N), .IW(IW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .fetch_valid_i(fv),
    .fetch_instr_i(instr), .fetch_vmask_i(vmask), .fetch_pred_i(pmask),
    .fetch_target_i(tgt), .replay_o(replay), .ready_o(ready),
    .deq_valid_o(dv), .deq_ready_i(dr), .deq_instr_o(dinstr),
    .deq_pred_o(dpred), .deq_target_o(dtgt));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic bit exp_replay(input bit f, input bit v, input logic [N-1:0] m, input logic [N-1:0] p);
    return v && !f && ((DEPTH - qi.size() < popc(m)) || ((|(p & m)) && qa.size() == 2));
  endfunction

  task automatic step(input bit f, input bit v, input logic [N-1:0] m,
                      input logic [N-1:0] p, input bit rdy);
    bit er, hp, ev, epred;
    @(negedge clk);
    flush = f; fv = v; vmask = m; pmask = p; dr = rdy;
    tgt = $urandom;
    for (int i = 0; i < N; i++) instr[i*IW +: IW] = $urandom;
    #1;
    hp = |(p & m);
    er = exp_replay(f, v, m, p);
    if (v && !f && hp && qa.size() == 2 && DEPTH - qi.size() >= popc(m))
      chk("R4 replay", 64'(replay), 64'(er));
    else
      chk("R3/R5 replay", 64'(replay), 64'(er));
    chk("R9 ready", 64'(ready), 64'((DEPTH - qi.size() >= N) && qa.size() != 2));
    ev = qi.size() > 0;
    chk(was_flush ? "R8 deq_valid" : "R6 deq_valid", 64'(dv), 64'(ev));
    if (ev) begin
      epred = qp[0];
      chk("R2/R5/R10 deq_instr", 64'(dinstr), 64'(qi[0]));
      chk("R7 deq_pred", 64'(dpred), 64'(epred));
      if (epred) chk("R7 deq_target", 64'(dtgt), 64'(qa[0]));
    end
    if (f) begin
      qi.delete(); qp.delete(); qa.delete();
    end else begin
      if (ev && rdy) begin
        if (qp[0]) void'(qa.pop_front());
        void'(qi.pop_front()); void'(qp.pop_front());
      end
      if (v && !er) begin
        for (int i = 0; i < N; i++)
          if (m[i]) begin qi.push_back(instr[i*IW +: IW]); qp.push_back(p[i]); end
        if (hp) qa.push_back(tgt);
      end
    end
    was_flush = f;
  endtask

  function automatic logic [N-1:0] onehot_or_none(input int pct);
    logic [N-1:0] r = '0;
    if (($urandom % 100) < pct) r[$urandom % N] = 1'b1;
    return r;
  endfunction

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    flush = 0; fv = 0; dr = 0; vmask = '0; pmask = '0; tgt = '0; instr = '0;
    #12;
    chk("R1 deq_valid", 64'(dv), 64'(0));
    chk("R1 ready", 64'(ready), 64'(1));
    chk("R1 replay", 64'(replay), 64'(0));
    rst_n = 1'b1;
    // R3: fill to exactly 4N with full bundles, then one more is replayed
    for (int k = 0; k < 5; k++) step(0, 1, '1, '0, 0);
    for (int k = 0; k < 3; k++) step(0, 1, '1, '0, 1);
    // R8: flush while full and while a bundle is offered
    step(1, 1, '1, '1, 1);
    step(0, 0, '0, '0, 1);
    // R4: two predicted single-slot bundles, third replayed despite room
    for (int k = 0; k < 3; k++) step(0, 1, 2'b01, 2'b01, 0);
    // R10: prediction on an invalid slot is ignored
    step(0, 1, 2'b01, 2'b10, 0);
    step(0, 0, '1, '1, 0);
    for (int k = 0; k < 8; k++) step(0, 0, '0, '0, 1);
    // random phases: filling, balanced, draining
    for (int ph = 0; ph < 3; ph++)
      for (int k = 0; k < 600; k++)
        step(($urandom % 60) == 0, ($urandom % 4) != 0, N'($urandom),
             onehot_or_none(40), ($urandom % 4) < ph + 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule